// File: doc/BRIEF.md
# Processor Low-Power State Controller

This block tracks the power-management state of a processor core and decides, cycle by cycle, how incoming interrupt and event lines are treated. It moves between five states: running (Normal), halted after a halt instruction (AutoHALT), clocks stopped on request (Stop-Grant), a short snoop-service window (HALT/Grant Snoop) and Sleep. From these it derives a clock-gate enable for the core and one-cycle service strobes for the events it accepts.

Interrupts that arrive while clocks are stopped are not lost. They are held in a pending register, one flag per kind, and released as a single strobe per kind once the core runs again. A configuration bit, set at power-on, chooses whether the core clocks really stop in the stopped states. The processor reset line is a functional input here. It is separate from the power-on reset `rstN`. Each state reacts to it in its own way.

Top module: `pwr_state_ctl`

## Requirements
- R1: After power-on reset, `pwrState` is Normal (encoding 0), `clkGateEn` is 1, every service strobe and `initDone` are 0, and the clock-stop configuration bit is 1. The state encodings are Normal=0, AutoHALT=1, Stop-Grant=2, Snoop=3, Sleep=4.
- R2: In Normal, `haltExec` (without `stopReq` or `initReq`) moves to AutoHALT on the next edge. Any SMI, INIT, BINIT, FLUSH or LINT request sampled in Normal gives its strobe for exactly one cycle, on the next edge.
- R3: In AutoHALT, an SMI, INIT, BINIT or LINT request, or a pending latched event, returns the machine to Normal on the next edge and strobes the matching services. A wake has priority over `stopReq`.
- R4: In AutoHALT, a FLUSH request alone is serviced with a one-cycle `svcFlush`, and the state stays AutoHALT.
- R5: `stopReq` in Normal or AutoHALT enters Stop-Grant. Dropping `stopReq` in Stop-Grant returns to the state held before entry (AutoHALT or Normal). This return has priority over sleep and snoop.
- R6: In Stop-Grant, BINIT and FLUSH requests give no strobe and leave no trace after the return.
- R7: SMI, INIT and LINT requests sampled in Stop-Grant are latched. Each kind is strobed exactly once, however often it arrived, on the first edge at which the machine is in Normal (or wakes from AutoHALT).
- R8: `initReq` in Stop-Grant while `stopReq` is held pulses `initDone` for one cycle and clears all pending latches. The state stays Stop-Grant.
- R9: In Stop-Grant, `sleepReq` enters Sleep, and `snoopHit` (without `sleepReq`) enters Snoop. Snoop lasts exactly SNOOP_CYCLES (default 3) cycles and then returns to Stop-Grant. Sleep returns to Stop-Grant when `sleepReq` drops. Event lines are ignored in Snoop and Sleep.
- R10: `clkGateEn` is 0 in Stop-Grant and Sleep while the configuration bit is 1. It is 1 in all other states. After `cfgWe` writes 0 to the bit, `clkGateEn` stays 1 in every state.
- R11: `initReq` in Normal or AutoHALT forces Normal, pulses `initDone`, clears the pending latches and suppresses all service strobes for that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous power-on reset, active low |
| haltExec | input | 1 | Halt instruction executed |
| stopReq | input | 1 | Clock-stop request, level |
| sleepReq | input | 1 | Sleep request, level |
| snoopHit | input | 1 | Bus snoop detected |
| initReq | input | 1 | Processor reset line (functional initialization) |
| smiReq | input | 1 | System management interrupt request |
| intrInitReq | input | 1 | INIT interrupt request |
| binitReq | input | 1 | Bus initialization request |
| flushReq | input | 1 | Cache flush request |
| lintReq | input | LINT_W (2) | Local interrupt lines |
| cfgWe | input | 1 | Write strobe for the clock-stop configuration bit |
| cfgStopClk | input | 1 | Value written to the configuration bit |
| pwrState | output | 3 | Current power state (encoding per R1) |
| clkGateEn | output | 1 | 1 = core clocks run |
| svcSmi | output | 1 | SMI service strobe |
| svcInit | output | 1 | INIT service strobe |
| svcBinit | output | 1 | BINIT service strobe |
| svcFlush | output | 1 | FLUSH service strobe |
| svcLint | output | LINT_W (2) | LINT service strobes |
| initDone | output | 1 | Pulse: initialization performed |

## Verification
The event lines are driven in every state, and each pattern separates one handling from another. SMI in Normal is strobed at once. BINIT and LINT0 in AutoHALT wake the core, while FLUSH there is strobed and the state holds. BINIT and FLUSH in Stop-Grant vanish, while repeated SMI and a LINT1 there come out exactly once on the way back through AutoHALT. The stop-request release is tried after entry from AutoHALT and after entry from Normal, which shows whether the saved return state is honoured. The snoop window is counted cycle by cycle. A pending INIT is wiped by a processor reset in Stop-Grant. Clearing the configuration bit shows whether the gating follows it.

// File: rtl/pwr_state_pkg.sv
package pwr_state_pkg;

  typedef enum logic [2:0] {
    PS_NORMAL    = 3'd0,
    PS_AUTOHALT  = 3'd1,
    PS_STOPGRANT = 3'd2,
    PS_SNOOP     = 3'd3,
    PS_SLEEP     = 3'd4
  } pwrState_e;

  // strobes from the control FSM to the event datapath
  typedef struct packed {
    logic captureEn;  // latch SMI/INIT/LINT into pending
    logic releaseEn;  // service live + pending events
    logic flushEn;    // FLUSH may be serviced
    logic clearPend;  // functional reset wipes pending
    logic gateZone;   // state where clocks may be stopped
  } ctrlStrobe_t;

endpackage

// File: rtl/pwr_state_ctrl.sv
module pwr_state_ctrl
  import pwr_state_pkg::*;
#(
  parameter int SNOOP_CYCLES = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        haltExec,
  input  logic        stopReq,
  input  logic        sleepReq,
  input  logic        snoopHit,
  input  logic        initReq,
  input  logic        wakeLive,
  input  logic        pendAny,
  output pwrState_e   state,
  output ctrlStrobe_t ctrl,
  output logic        initDone
);

  localparam int CNT_W = (SNOOP_CYCLES > 1) ? $clog2(SNOOP_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SNOOP_CYCLES - 1);

  pwrState_e        nextState;
  logic             returnHalt, nextReturnHalt;
  logic             wakeHalt;
  logic [CNT_W-1:0] snoopCnt;
  logic             initZone;

  assign initZone = (state == PS_NORMAL) || (state == PS_AUTOHALT) ||
                    (state == PS_STOPGRANT);

  always_comb begin
    nextState      = state;
    nextReturnHalt = returnHalt;
    wakeHalt       = 1'b0;
    case (state)
      PS_NORMAL: begin
        if (!initReq) begin
          if (stopReq) begin
            nextState      = PS_STOPGRANT;
            nextReturnHalt = 1'b0;
          end else if (haltExec) begin
            nextState = PS_AUTOHALT;
          end
        end
      end
      PS_AUTOHALT: begin
        if (initReq) begin
          nextState = PS_NORMAL;
        end else if (wakeLive || pendAny) begin
          nextState = PS_NORMAL;
          wakeHalt  = 1'b1;
        end else if (stopReq) begin
          nextState      = PS_STOPGRANT;
          nextReturnHalt = 1'b1;
        end
      end
      PS_STOPGRANT: begin
        if (!stopReq)      nextState = returnHalt ? PS_AUTOHALT : PS_NORMAL;
        else if (sleepReq) nextState = PS_SLEEP;
        else if (snoopHit) nextState = PS_SNOOP;
      end
      PS_SNOOP: begin
        if (snoopCnt == CNT_LAST) nextState = PS_STOPGRANT;
      end
      PS_SLEEP: begin
        if (!sleepReq) nextState = PS_STOPGRANT;
      end
      default: nextState = PS_NORMAL;
    endcase
  end

  always_comb begin
    ctrl.captureEn = (state == PS_STOPGRANT) && !initReq;
    ctrl.releaseEn = !initReq && ((state == PS_NORMAL) || wakeHalt);
    ctrl.flushEn   = !initReq && ((state == PS_NORMAL) || (state == PS_AUTOHALT));
    ctrl.clearPend = initReq && initZone;
    ctrl.gateZone  = (state == PS_STOPGRANT) || (state == PS_SLEEP);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= PS_NORMAL;
      returnHalt <= 1'b0;
      snoopCnt   <= '0;
      initDone   <= 1'b0;
    end else begin
      state      <= nextState;
      returnHalt <= nextReturnHalt;
      snoopCnt   <= (state == PS_SNOOP) ? snoopCnt + 1'b1 : '0;
      initDone   <= initReq && initZone;
    end
  end

  // R2: halt in Normal leads to AutoHALT
  a_r2_halt_entry: assert property (@(posedge clk) disable iff (!rstN)
    (state == PS_NORMAL && haltExec && !stopReq && !initReq) |=> (state == PS_AUTOHALT));

  // R5: Stop-Grant holds while stop is held and nothing else arrives
  a_r5_stop_hold: assert property (@(posedge clk) disable iff (!rstN)
    (state == PS_STOPGRANT && stopReq && !sleepReq && !snoopHit) |=> (state == PS_STOPGRANT));

  // R8: functional reset keeps Stop-Grant
  a_r8_init_stays: assert property (@(posedge clk) disable iff (!rstN)
    (state == PS_STOPGRANT && stopReq && initReq && !sleepReq && !snoopHit)
      |=> (state == PS_STOPGRANT && initDone));

  // R9: Sleep leaves only to Stop-Grant
  a_r9_sleep_exit: assert property (@(posedge clk) disable iff (!rstN)
    (state == PS_SLEEP && !sleepReq) |=> (state == PS_STOPGRANT));

  // R9: Snoop is never entered from outside Stop-Grant
  a_r9_snoop_origin: assert property (@(posedge clk) disable iff (!rstN)
    $rose(state == PS_SNOOP) |-> ($past(state) == PS_STOPGRANT));

endmodule

// File: rtl/pwr_state_dp.sv
module pwr_state_dp
  import pwr_state_pkg::*;
#(
  parameter int LINT_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       ctrl,
  input  logic              smiReq,
  input  logic              intrInitReq,
  input  logic              binitReq,
  input  logic              flushReq,
  input  logic [LINT_W-1:0] lintReq,
  input  logic              cfgWe,
  input  logic              cfgStopClk,
  output logic              pendAny,
  output logic              clkGateEn,
  output logic              svcSmi,
  output logic              svcInit,
  output logic              svcBinit,
  output logic              svcFlush,
  output logic [LINT_W-1:0] svcLint
);

  logic              pendSmi, pendInit;
  logic [LINT_W-1:0] pendLint;
  logic              stopClkBit;

  // single-kind pending latch with strobe; shared by SMI, INIT and each LINT bit
  function automatic logic nextPend(input logic cur, input logic req, input ctrlStrobe_t c);
    if (c.clearPend)      return 1'b0;
    else if (c.captureEn) return cur | req;
    else if (c.releaseEn) return 1'b0;
    else                  return cur;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendSmi  <= 1'b0;
      pendInit <= 1'b0;
      svcSmi   <= 1'b0;
      svcInit  <= 1'b0;
      svcBinit <= 1'b0;
      svcFlush <= 1'b0;
    end else begin
      pendSmi  <= nextPend(pendSmi, smiReq, ctrl);
      pendInit <= nextPend(pendInit, intrInitReq, ctrl);
      svcSmi   <= ctrl.releaseEn && (smiReq || pendSmi);
      svcInit  <= ctrl.releaseEn && (intrInitReq || pendInit);
      svcBinit <= ctrl.releaseEn && binitReq;
      svcFlush <= ctrl.flushEn && flushReq;
    end
  end

  for (genvar i = 0; i < LINT_W; i++) begin : g_lint
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        pendLint[i] <= 1'b0;
        svcLint[i]  <= 1'b0;
      end else begin
        pendLint[i] <= nextPend(pendLint[i], lintReq[i], ctrl);
        svcLint[i]  <= ctrl.releaseEn && (lintReq[i] || pendLint[i]);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      stopClkBit <= 1'b1;
    else if (cfgWe) stopClkBit <= cfgStopClk;
  end

  assign pendAny   = pendSmi || pendInit || (|pendLint);
  assign clkGateEn = !(ctrl.gateZone && stopClkBit);

  // R6: nothing from BINIT or FLUSH survives a capture cycle
  a_r6_no_binit_flush: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.captureEn |=> (!svcBinit && !svcFlush));

  // R7: a held pending flag produces no strobe until released
  a_r7_pend_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.captureEn && !ctrl.releaseEn) |=> !svcSmi && !svcInit && (svcLint == '0));

  // R11: functional reset empties the pending latches
  a_r11_pend_clear: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.clearPend |=> !pendAny);

endmodule

// File: rtl/pwr_state_ctl.sv
module pwr_state_ctl
  import pwr_state_pkg::*;
#(
  parameter int SNOOP_CYCLES = 3,
  parameter int LINT_W       = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              haltExec,
  input  logic              stopReq,
  input  logic              sleepReq,
  input  logic              snoopHit,
  input  logic              initReq,
  input  logic              smiReq,
  input  logic              intrInitReq,
  input  logic              binitReq,
  input  logic              flushReq,
  input  logic [LINT_W-1:0] lintReq,
  input  logic              cfgWe,
  input  logic              cfgStopClk,
  output logic [2:0]        pwrState,
  output logic              clkGateEn,
  output logic              svcSmi,
  output logic              svcInit,
  output logic              svcBinit,
  output logic              svcFlush,
  output logic [LINT_W-1:0] svcLint,
  output logic              initDone
);

  pwrState_e   state;
  ctrlStrobe_t ctrl;
  logic        pendAny;
  logic        wakeLive;

  assign wakeLive = smiReq || intrInitReq || binitReq || (|lintReq);

  pwr_state_ctrl #(.SNOOP_CYCLES(SNOOP_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .haltExec(haltExec), .stopReq(stopReq),
    .sleepReq(sleepReq), .snoopHit(snoopHit), .initReq(initReq),
    .wakeLive(wakeLive), .pendAny(pendAny), .state(state), .ctrl(ctrl),
    .initDone(initDone)
  );

  pwr_state_dp #(.LINT_W(LINT_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .smiReq(smiReq),
    .intrInitReq(intrInitReq), .binitReq(binitReq), .flushReq(flushReq),
    .lintReq(lintReq), .cfgWe(cfgWe), .cfgStopClk(cfgStopClk),
    .pendAny(pendAny), .clkGateEn(clkGateEn), .svcSmi(svcSmi),
    .svcInit(svcInit), .svcBinit(svcBinit), .svcFlush(svcFlush),
    .svcLint(svcLint)
  );

  assign pwrState = state;

  // R11: an initialization pulse never coincides with a service strobe
  a_r11_quiet_init: assert property (@(posedge clk) disable iff (!rstN)
    initDone |-> !(svcSmi || svcInit || svcBinit || svcFlush || (|svcLint)));

  // R10: clocks always run during snoop service
  a_r10_snoop_clock: assert property (@(posedge clk) disable iff (!rstN)
    (pwrState == 3'd3) |-> clkGateEn);

endmodule

// File: tb/pwr_state_ctl_tb.sv
module pwr_state_ctl_tb;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic haltExec = 0, stopReq = 0, sleepReq = 0, snoopHit = 0, initReq = 0;
  logic smiReq = 0, intrInitReq = 0, binitReq = 0, flushReq = 0;
  logic [1:0] lintReq = '0;
  logic cfgWe = 0, cfgStopClk = 0;
  logic [2:0] pwrState;
  logic clkGateEn, svcSmi, svcInit, svcBinit, svcFlush, initDone;
  logic [1:0] svcLint;

  always #4 clk = ~clk;

  pwr_state_ctl u_dut (
    .clk(clk), .rstN(rstN), .haltExec(haltExec), .stopReq(stopReq),
    .sleepReq(sleepReq), .snoopHit(snoopHit), .initReq(initReq),
    .smiReq(smiReq), .intrInitReq(intrInitReq), .binitReq(binitReq),
    .flushReq(flushReq), .lintReq(lintReq), .cfgWe(cfgWe),
    .cfgStopClk(cfgStopClk), .pwrState(pwrState), .clkGateEn(clkGateEn),
    .svcSmi(svcSmi), .svcInit(svcInit), .svcBinit(svcBinit),
    .svcFlush(svcFlush), .svcLint(svcLint), .initDone(initDone)
  );

  localparam logic [11:0] I_NONE = 12'h000, I_L0 = 12'h001, I_L1 = 12'h002,
    I_FLUSH = 12'h004, I_BINIT = 12'h008, I_INTR = 12'h010, I_SMI = 12'h020,
    I_RST = 12'h040, I_SNOOP = 12'h080, I_SLEEP = 12'h100, I_STOP = 12'h200,
    I_HALT = 12'h400, I_CFG0 = 12'h800;
  localparam logic [5:0] V_NONE = 6'b0, V_SMI = 6'b100000, V_INIT = 6'b010000,
    V_BINIT = 6'b001000, V_FLUSH = 6'b000100, V_L1 = 6'b000010, V_L0 = 6'b000001;

  typedef struct {
    logic [2:0] st;
    logic       gate;
    logic [5:0] svc;
    logic       done;
    string      tag;
  } exp_t;

  exp_t expQ[$];
  int checkCnt = 0;
  int failCnt = 0;

  task automatic step(input logic [11:0] in, input logic [2:0] st, input logic gate,
                      input logic [5:0] svc, input logic done, input string tag);
    exp_t e;
    @(negedge clk);
    {cfgWe, haltExec, stopReq, sleepReq, snoopHit, initReq, smiReq, intrInitReq,
     binitReq, flushReq, lintReq} = in;
    cfgStopClk = 1'b0;
    e.st = st; e.gate = gate; e.svc = svc; e.done = done; e.tag = tag;
    expQ.push_back(e);
  endtask

  // monitor: compares one result per clock, after the edge has settled
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (expQ.size() > 0) begin
        exp_t e;
        logic [5:0] gotSvc;
        e = expQ.pop_front();
        gotSvc = {svcSmi, svcInit, svcBinit, svcFlush, svcLint};
        checkCnt++;
        if (pwrState !== e.st || clkGateEn !== e.gate || gotSvc !== e.svc ||
            initDone !== e.done) begin
          failCnt++;
          $display("FAIL %s: state/gate/svc/done = %0d/%0b/%b/%0b expected %0d/%0b/%b/%0b",
                   e.tag, pwrState, clkGateEn, gotSvc, initDone, e.st, e.gate, e.svc, e.done);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    checkCnt++;
    failCnt++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    checkCnt++;
    if (pwrState !== 3'd0 || clkGateEn !== 1'b1 || initDone !== 1'b0 ||
        {svcSmi, svcInit, svcBinit, svcFlush, svcLint} !== 6'b0) begin
      failCnt++;
      $display("FAIL R1: state=%0d gate=%0b expected 0 1", pwrState, clkGateEn);
    end
    rstN = 1'b1;

    step(I_NONE,  0, 1, V_NONE,  0, "R1 idle after reset");
    step(I_SMI,   0, 1, V_SMI,   0, "R2 SMI in Normal");
    step(I_HALT,  1, 1, V_NONE,  0, "R2 halt to AutoHALT");
    step(I_FLUSH, 1, 1, V_FLUSH, 0, "R4 flush in AutoHALT");
    step(I_BINIT, 0, 1, V_BINIT, 0, "R3 BINIT wakes");
    step(I_HALT,  1, 1, V_NONE,  0, "R2 halt again");
    step(I_L0,    0, 1, V_L0,    0, "R3 LINT0 wakes");
    step(I_HALT,  1, 1, V_NONE,  0, "R2 halt third");
    step(I_STOP,  2, 0, V_NONE,  0, "R5 stop from AutoHALT, R10 gated");
    step(I_STOP | I_SMI, 2, 0, V_NONE, 0, "R7 SMI latched");
    step(I_STOP | I_SMI, 2, 0, V_NONE, 0, "R7 SMI again");
    step(I_STOP | I_BINIT | I_FLUSH, 2, 0, V_NONE, 0, "R6 BINIT/FLUSH ignored");
    step(I_STOP | I_L1, 2, 0, V_NONE, 0, "R7 LINT1 latched");
    step(I_NONE,  1, 1, V_NONE,  0, "R5 return to AutoHALT");
    step(I_NONE,  0, 1, V_SMI | V_L1, 0, "R7 pending serviced once, R6 no binit/flush");
    step(I_NONE,  0, 1, V_NONE,  0, "R7 no second service");
    step(I_STOP,  2, 0, V_NONE,  0, "R5 stop from Normal");
    step(I_STOP | I_SNOOP, 3, 1, V_NONE, 0, "R9 snoop entry, R10 clocks on");
    step(I_STOP,  3, 1, V_NONE,  0, "R9 snoop cycle 2");
    step(I_STOP,  3, 1, V_NONE,  0, "R9 snoop cycle 3");
    step(I_STOP,  2, 0, V_NONE,  0, "R9 snoop done");
    step(I_STOP | I_SLEEP, 4, 0, V_NONE, 0, "R9 sleep entry, R10 gated");
    step(I_STOP | I_SLEEP | I_INTR | I_SMI, 4, 0, V_NONE, 0, "R9 events ignored in Sleep");
    step(I_STOP,  2, 0, V_NONE,  0, "R9 sleep exit");
    step(I_STOP | I_INTR, 2, 0, V_NONE, 0, "R7 INIT latched");
    step(I_STOP | I_RST, 2, 0, V_NONE, 1, "R8 init in Stop-Grant stays");
    step(I_NONE,  0, 1, V_NONE,  0, "R5 return to Normal");
    step(I_NONE,  0, 1, V_NONE,  0, "R8 pending cleared by init");
    step(I_CFG0,  0, 1, V_NONE,  0, "R10 config write");
    step(I_STOP,  2, 1, V_NONE,  0, "R10 Stop-Grant ungated");
    step(I_STOP | I_SLEEP, 4, 1, V_NONE, 0, "R10 Sleep ungated");
    step(I_NONE,  2, 1, V_NONE,  0, "R9 sleep drop first");
    step(I_NONE,  0, 1, V_NONE,  0, "R5 back to Normal");
    step(I_HALT,  1, 1, V_NONE,  0, "R2 halt");
    step(I_RST | I_SMI, 0, 1, V_NONE, 1, "R11 init in AutoHALT");
    step(I_RST | I_FLUSH, 0, 1, V_NONE, 1, "R11 init in Normal");
    step(I_NONE,  0, 1, V_NONE,  0, "R11 idle after init");

    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

endmodule